// File: doc/BRIEF.md
# Selectable Input Conditioning Stage

This block sits between a set of asynchronous input signals and a configurable logic fabric. Each of its lanes takes one external signal and hands the fabric a conditioned version of it. Every lane has its own three-bit mode code. The code picks one of four treatments: a copy re-timed through two flip-flops, a raw combinational bypass, a one-clock pulse on each low-to-high change, or a one-clock pulse on each high-to-low change.

Every lane runs a three-flop chain. The second flop holds the re-timed level, and the third holds that level one clock older. The edge pulses come from comparing these two stages. A pulse is therefore aligned to the fabric clock and lasts exactly one cycle. The chain always runs, whatever mode is selected. The mode code only steers an output multiplexer, so changing a code does not lose the lane's history. Code values that name no treatment fall back to the re-timed copy. The lane count and the synchronizer depth are parameters.

Top module: `incond_stage`

## Requirements
- R1: While reset is asserted, every lane that is not in bypass outputs 0. On the first clock edge after reset is released, no lane outputs a pulse and no re-timed lane outputs 1.
- R2: Code 3'b000 (synchronized) outputs the lane input delayed by exactly two fabric clock edges.
- R3: Code 3'b001 (bypass) drives the output from the input combinationally, with no register in the path.
- R4: Code 3'b010 (rising edge) gives one clock of high output for each low-to-high input change seen at the clock. The pulse starts on the second edge after the change. The count of pulses equals the count of rising changes.
- R5: Code 3'b011 (falling edge) gives one clock of high output for each high-to-low input change, with the same timing and counting rule as R4.
- R6: Codes 3'b100 through 3'b111 behave exactly like code 3'b000.
- R7: Lanes are independent. Each lane's output depends only on its own input and its own code.
- R8: The synchronizer chain runs in every mode. After a lane leaves bypass for synchronized mode, its output at once shows the input as it stood two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears every chain flop |
| pins_in | input | LANES (16) | Asynchronous external inputs, one per lane |
| mode_cfg | input | LANES x 3 | Packed array of per-lane mode codes, lane i at mode_cfg[i] |
| cond_out | output | LANES (16) | Conditioned outputs to the fabric |

## Verification
On every clock edge, the checker compares each lane against the input history sampled at earlier edges. For a synchronized or fallback code, the output must match the input two edges back. For an edge code, the output must match the difference between the input two and three edges back. A bypass lane must match its input in the same cycle. The checker also watches for quiet outputs over the first edges after reset. Only the bench scenarios can show the following: that the pulse count matches the edge count over a long run of changes, that differently coded lanes do not disturb each other, and that a mode change keeps the chain's history.

// File: rtl/incond_pkg.sv
package incond_pkg;

   // width of one lane's mode code
   localparam int unsigned MODE_W = 3;

   typedef logic [MODE_W-1:0] mode_code_t;

   // decoded treatment; undefined codes are folded onto MODE_SYNC by the decoder
   typedef enum logic [MODE_W-1:0] {
      MODE_SYNC   = 3'b000,
      MODE_DIRECT = 3'b001,
      MODE_RISE   = 3'b010,
      MODE_FALL   = 3'b011
   } mode_e;

   // taps taken from one lane's synchronizer chain
   typedef struct packed {
      logic level;   // re-timed level
      logic rise;    // level went 0 -> 1 on the last edge
      logic fall;    // level went 1 -> 0 on the last edge
   } taps_t;

endpackage

// File: rtl/incond_sync_chain.sv
module incond_sync_chain
   import incond_pkg::*;
#(
   parameter int unsigned DEPTH = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output taps_t taps
);

   // DEPTH flops re-time the input, and one extra flop keeps the previous level
   localparam int unsigned NSTG = DEPTH + 1;

   logic [NSTG-1:0] stg;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("incond_sync_chain: DEPTH must be at least 2");
      end

      for (genvar s = 0; s < NSTG; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= 1'b0;
               else        stg[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= 1'b0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   // both compared stages clear together, so no pulse can follow reset directly
   always_comb begin
      taps.level = stg[DEPTH-1];
      taps.rise  =  stg[DEPTH-1] & ~stg[DEPTH];
      taps.fall  = ~stg[DEPTH-1] &  stg[DEPTH];
   end

endmodule

// File: rtl/incond_mode_decode.sv
module incond_mode_decode
   import incond_pkg::*;
(
   input  mode_code_t code,
   output mode_e      mode
);

   // codes with the top bit set select no treatment of their own and fall back to sync
   always_comb begin
      unique case (code)
         3'b001:  mode = MODE_DIRECT;
         3'b010:  mode = MODE_RISE;
         3'b011:  mode = MODE_FALL;
         default: mode = MODE_SYNC;
      endcase
   end

endmodule

// File: rtl/incond_lane.sv
module incond_lane
   import incond_pkg::*;
#(
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  mode_code_t code,
   output logic       dout
);

   taps_t taps;
   mode_e mode;

   // the chain always runs, so a mode change keeps the lane's history
   incond_sync_chain #(
      .DEPTH (SYNC_DEPTH)
   ) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .taps  (taps)
   );

   incond_mode_decode u_dec (
      .code (code),
      .mode (mode)
   );

   always_comb begin
      unique case (mode)
         MODE_DIRECT: dout = din;
         MODE_RISE:   dout = taps.rise;
         MODE_FALL:   dout = taps.fall;
         default:     dout = taps.level;
      endcase
   end

endmodule

// File: rtl/incond_stage.sv
module incond_stage
   import incond_pkg::*;
#(
   parameter int unsigned LANES      = 16,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES-1:0]             pins_in,
   input  logic [LANES-1:0][MODE_W-1:0] mode_cfg,
   output logic [LANES-1:0]             cond_out
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("incond_stage: LANES must be at least 1");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("incond_stage: SYNC_DEPTH must be at least 2");
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         incond_lane #(
            .SYNC_DEPTH (SYNC_DEPTH)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pins_in[i]),
            .code  (mode_cfg[i]),
            .dout  (cond_out[i])
         );
      end
   endgenerate

endmodule

// File: rtl/incond_chk.sv
module incond_chk #(
   parameter int unsigned LANES      = 16,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [LANES-1:0]       pins,
   input logic [LANES-1:0][2:0]  mode,
   input logic [LANES-1:0]       cond
);

   // clock edges since reset release, held at its top value
   logic [2:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cyc <= 3'd0;
      else if (cyc != 3'd7) cyc <= cyc + 3'd1;
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane_chk

         // R1: quiet outputs on the first edges after reset
         p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc <= 3'd1 && mode[i] != 3'b001) |-> !cond[i]);

         // R3: bypass follows the input in the same cycle
         p_bypass_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == 3'b001) |-> (cond[i] == pins[i]));

         if (SYNC_DEPTH == 2) begin : g_depth2
            // R2: synchronized copy, two edges late
            p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
               (cyc >= 3'd3 && mode[i] == 3'b000) |-> (cond[i] == $past(pins[i], 2)));

            // R6: undefined codes behave as sync
            p_unused_code_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
               (cyc >= 3'd3 && mode[i][2]) |-> (cond[i] == $past(pins[i], 2)));

            // R4: rising pulse
            p_rise_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
               (cyc >= 3'd4 && mode[i] == 3'b010) |->
               (cond[i] == ($past(pins[i], 2) && !$past(pins[i], 3))));

            // R5: falling pulse
            p_fall_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (cyc >= 3'd4 && mode[i] == 3'b011) |->
               (cond[i] == (!$past(pins[i], 2) && $past(pins[i], 3))));
         end
      end
   endgenerate

endmodule

bind incond_stage incond_chk #(
   .LANES      (LANES),
   .SYNC_DEPTH (SYNC_DEPTH)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .pins  (pins_in),
   .mode  (mode_cfg),
   .cond  (cond_out)
);

// File: tb/sim_incond_stage.sv
`timescale 1ns/1ps
module sim_incond_stage;

   localparam int LANES = 16;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [LANES-1:0]       pins_in = '0;
   logic [LANES-1:0][2:0]  mode_cfg = '0;
   logic [LANES-1:0]       cond_out;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   incond_stage #(.LANES(LANES), .SYNC_DEPTH(2)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_in  (pins_in),
      .mode_cfg (mode_cfg),
      .cond_out (cond_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_all(input logic [2:0] code);
      for (int l = 0; l < LANES; l++) mode_cfg[l] = code;
   endtask

   // R1: quiet during reset and on the first edge after release
   task automatic t_reset;
      set_all(3'b000);
      pins_in = 16'hFFFF;
      step(3);
      chk("R1 sync lanes zero in reset", cond_out, 16'h0000);
      set_all(3'b010);
      step(1);
      rst_n = 1'b1;
      step(1);
      chk("R1 no pulse first edge", cond_out, 16'h0000);
      step(1);
      chk("R4 pulse from cleared chain", cond_out, 16'hFFFF);
      step(1);
      chk("R4 pulse one cycle wide", cond_out, 16'h0000);
   endtask

   // R2 and R6: two-edge latency
   task automatic t_sync(input bit unused_codes, input string tag);
      for (int l = 0; l < LANES; l++)
         mode_cfg[l] = unused_codes ? (3'b100 | 3'(l % 4)) : 3'b000;
      pins_in = 16'h0000;
      step(4);
      #1.1 pins_in = 16'hA5C3;
      step(1);
      chk({tag, " old value after one edge"}, cond_out, 16'h0000);
      step(1);
      chk({tag, " new value after two edges"}, cond_out, 16'hA5C3);
      #0.7 pins_in = 16'h5A3C;
      step(1);
      chk({tag, " holds before second edge"}, cond_out, 16'hA5C3);
      step(1);
      chk({tag, " second change"}, cond_out, 16'h5A3C);
   endtask

   // R3: combinational bypass
   task automatic t_bypass;
      set_all(3'b001);
      pins_in = 16'h3C5A;
      #0.4;
      chk("R3 bypass immediate", cond_out, 16'h3C5A);
      #0.6 pins_in = 16'hC3A5;
      #0.4;
      chk("R3 bypass follows second value", cond_out, 16'hC3A5);
   endtask

   // R4/R5: pulse count equals edge count, per lane
   task automatic t_edge_count(input logic [2:0] code, input string tag);
      int exp_n [LANES];
      int act_n [LANES];
      logic [15:0] v;
      logic [15:0] prev;
      logic [31:0] seed;
      for (int l = 0; l < LANES; l++) begin exp_n[l] = 0; act_n[l] = 0; end
      set_all(code);
      pins_in = 16'h0000;
      step(4);
      prev = 16'h0000;
      seed = 32'h1234_5678 ^ {29'd0, code};
      for (int k = 0; k < 40; k++) begin
         seed ^= seed << 13;
         seed ^= seed >> 17;
         seed ^= seed << 5;
         v = seed[15:0];
         for (int l = 0; l < LANES; l++) begin
            if (code == 3'b010 && !prev[l] && v[l]) exp_n[l]++;
            if (code == 3'b011 && prev[l] && !v[l]) exp_n[l]++;
         end
         #1.3 pins_in = v;
         for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            for (int l = 0; l < LANES; l++) if (cond_out[l]) act_n[l]++;
         end
         prev = v;
      end
      for (int h = 0; h < 4; h++) begin
         @(negedge clk);
         for (int l = 0; l < LANES; l++) if (cond_out[l]) act_n[l]++;
      end
      for (int l = 0; l < LANES; l++)
         chk($sformatf("%s pulse count lane %0d", tag, l), act_n[l], exp_n[l]);
   endtask

   // R7: lanes with different codes side by side
   task automatic t_mixed;
      for (int l = 0; l < LANES; l++) mode_cfg[l] = 3'(l % 4);
      pins_in = 16'h0000;
      step(4);
      #1.0 pins_in = 16'hFFFF;
      #0.5;
      chk("R7 only bypass lanes move at once", cond_out, 16'h2222);
      step(1);
      chk("R7 one edge in", cond_out, 16'h2222);
      step(1);
      chk("R7 two edges: sync and rise high", cond_out, 16'h7777);
      step(1);
      chk("R7 three edges: rise pulse over", cond_out, 16'h3333);
      #1.0 pins_in = 16'h0000;
      step(2);
      chk("R7 fall lanes pulse only", cond_out, 16'h8888);
      step(1);
      chk("R7 all quiet", cond_out, 16'h0000);
   endtask

   // R8: history survives a detour through bypass
   task automatic t_mode_switch;
      set_all(3'b000);
      pins_in = 16'hFFFF;
      step(4);
      #1.0 begin pins_in = 16'h0000; set_all(3'b001); end
      #0.5;
      chk("R8 bypass shows new level", cond_out, 16'h0000);
      step(1);
      set_all(3'b000);
      #0.5;
      chk("R8 sync shows level two edges back", cond_out, 16'hFFFF);
      step(1);
      chk("R8 sync catches up", cond_out, 16'h0000);
   endtask

   initial begin
      t_reset();
      t_sync(1'b0, "R2");
      t_bypass();
      t_edge_count(3'b010, "R4");
      t_edge_count(3'b011, "R5");
      t_sync(1'b1, "R6");
      t_mixed();
      t_mode_switch();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         total++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule